// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel behind a byte-wide register window of four addresses. Software picks a counting behaviour by writing a control byte, then loads the initial count as two byte writes to the data address. The channel then counts down by one on every clock and drives an interrupt line. Three behaviours are available: a single terminal-count event that leaves the line high, a periodic rate generator, and a one-shot strobe.

Software reads a stable count without stopping the counter. A latch command freezes a snapshot, and the next two data reads return that snapshot a byte at a time. When no snapshot is pending, data reads return the live count. Writing a control byte disarms the channel until a fresh count has been fully written.

Top module: `interval_timer_chan`

## Requirements
- R1: Data writes and reads use address 0 and control writes use address 3. Writes to addresses 1 and 2 change nothing. Reads from any address other than 0 return 0.
- R2: A control byte is accepted only when bits 7:6 are 00. Bits 5:4 = 00 is a latch command. Bits 5:4 = 11 selects a behaviour from bits 3:1: 000 is terminal count (0x30), 010 is rate generator (0x34) and 100 is strobe (0x38). Bit 0 is ignored. Every other control byte is ignored.
- R3: The count is written low byte first, then high byte. Counting starts only at the high byte: the count equals the written value N after that write's clock edge and drops by one on each later edge.
- R4: An accepted behaviour byte freezes the count and stops all interrupt activity until a new count is written. It also returns both byte pointers to the low byte.
- R5: In terminal-count behaviour, irq_out is low after the control byte and after a count load. It goes high exactly N edges after the load and stays high.
- R6: In rate-generator behaviour, the count runs N, N-1, ..., 1 and then reloads N. irq_out is low for exactly the one clock in which the count is 1, giving a period of N clocks (N at least 2).
- R7: In rate-generator behaviour, a count written while the channel is running only replaces the reload value. It takes effect at the next reload.
- R8: In strobe behaviour, irq_out stays high, goes low for exactly one clock N edges after the load, and does not pulse again until the next load.
- R9: A loaded count of 0 acts as 65536.
- R10: A latch command captures the count held just before its edge. The next two data reads return the snapshot's low byte and then its high byte, while the counter keeps running.
- R11: A latch command is ignored while a snapshot is still pending.
- R12: With no snapshot pending, data reads return the live count, low byte then high byte, alternating.
- R13: After reset, irq_out is high, the count is 0 and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 2 | Register address within the window |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while rd_en is high |
| irq_out | output | 1 | Interrupt / timer output line |

## Verification
A wrong count or a wrong reload value shows on irq_out as an edge that arrives one or more clocks off the expected cycle. In rate-generator behaviour this error repeats in every period, so a single sweep of periods exposes it within a few periods. A byte pointer left on the wrong side shows up at the first latch read or count load after the fault, as swapped bytes or as a count that never starts. A snapshot that fails to freeze, or that can be overwritten, shows as a difference between the value read back and the value computed from the number of clocks since the load.

// File: rtl/itc_pkg.sv
`timescale 1ns/1ps
package itc_pkg;
    parameter int BYTE_W = 8;
    parameter int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        MODE_TC     = 3'd0,
        MODE_RATE   = 3'd2,
        MODE_STROBE = 3'd4
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic               armed;
        logic               fired;
        logic               out;
        logic               hi_next;
        logic [BYTE_W-1:0]  lo_stage;
        logic [CNT_W-1:0]   reload;
        logic [CNT_W-1:0]   count;
    } core_st_t;

    typedef struct packed {
        logic               latched;
        logic               rd_hi;
        logic [CNT_W-1:0]   snap;
    } rb_st_t;
endpackage

// File: rtl/itc_bus_decode.sv
`timescale 1ns/1ps
module itc_bus_decode
    import itc_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_OFS = 0,
    parameter int CTRL_OFS = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              mode_wr,
    output mode_e             mode_sel,
    output logic              latch_cmd,
    output logic              data_wr,
    output logic              data_rd
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

    logic ctrl_hit;
    logic chan_ok;
    logic mode_ok;

    always_comb begin
        ctrl_hit = wr_en && (addr == A_CTRL);
        chan_ok  = (wdata[7:6] == 2'b00);
        mode_ok  = 1'b1;
        mode_sel = MODE_TC;
        case (wdata[3:1])
            3'b000:  mode_sel = MODE_TC;
            3'b010:  mode_sel = MODE_RATE;
            3'b100:  mode_sel = MODE_STROBE;
            default: mode_ok  = 1'b0;
        endcase
        latch_cmd = ctrl_hit && chan_ok && (wdata[5:4] == 2'b00);
        mode_wr   = ctrl_hit && chan_ok && (wdata[5:4] == 2'b11) && mode_ok;
        data_wr   = wr_en && (addr == A_DATA);
        data_rd   = rd_en && (addr == A_DATA);
    end
endmodule

// File: rtl/itc_count_core.sv
`timescale 1ns/1ps
module itc_count_core
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  mode_e             mode_sel,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              out_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    core_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.armed) begin
            unique case (st_q.mode)
                MODE_RATE: begin
                    st_d.count = (st_q.count == ONE) ? st_q.reload : st_q.count - ONE;
                    st_d.out   = (st_d.count != ONE);
                end
                MODE_TC: begin
                    st_d.count = st_q.count - ONE;
                    if (st_q.count == ONE) st_d.out = 1'b1;
                end
                MODE_STROBE: begin
                    st_d.count = st_q.count - ONE;
                    st_d.out   = 1'b1;
                    if (st_q.count == ONE && !st_q.fired) begin
                        st_d.out   = 1'b0;
                        st_d.fired = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (mode_wr) begin
            st_d.mode    = mode_sel;
            st_d.armed   = 1'b0;
            st_d.fired   = 1'b0;
            st_d.hi_next = 1'b0;
            st_d.count   = st_q.count;
            st_d.out     = (mode_sel != MODE_TC);
        end else if (data_wr) begin
            if (!st_q.hi_next) begin
                st_d.lo_stage = wdata;
                st_d.hi_next  = 1'b1;
            end else begin
                st_d.hi_next = 1'b0;
                st_d.reload  = {wdata, st_q.lo_stage};
                if (!(st_q.mode == MODE_RATE && st_q.armed)) begin
                    st_d.count = {wdata, st_q.lo_stage};
                    st_d.armed = 1'b1;
                    st_d.fired = 1'b0;
                    st_d.out   = (st_q.mode != MODE_TC);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_TC;
            st_q.out      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign out_o   = st_q.out;

    p_hold_on_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (st_q.count == $past(st_q.count) && !st_q.armed));

    p_tc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_TC && st_q.out && !mode_wr && !data_wr) |=> st_q.out);

    p_rate_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && st_q.mode == MODE_RATE && st_q.count == ONE && !mode_wr)
        |=> (st_q.count == $past(st_q.reload)));

    p_strobe_one_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_STROBE && !st_q.out && !mode_wr) |=> st_q.out);
endmodule

// File: rtl/itc_readback.sv
`timescale 1ns/1ps
module itc_readback
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              latch_cmd,
    input  logic              data_rd,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [BYTE_W-1:0] rd_byte
);
    rb_st_t rb_q, rb_d;
    logic [CNT_W-1:0] src;

    always_comb begin
        rb_d = rb_q;
        if (mode_wr) begin
            rb_d.latched = 1'b0;
            rb_d.rd_hi   = 1'b0;
        end else if (latch_cmd && !rb_q.latched) begin
            rb_d.latched = 1'b1;
            rb_d.rd_hi   = 1'b0;
            rb_d.snap    = live_cnt;
        end else if (data_rd) begin
            rb_d.rd_hi = !rb_q.rd_hi;
            if (rb_q.rd_hi) rb_d.latched = 1'b0;
        end
        src     = rb_q.latched ? rb_q.snap : live_cnt;
        rd_byte = rb_q.rd_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    p_second_latch_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.latched && latch_cmd) |=> (rb_q.latched && rb_q.snap == $past(rb_q.snap)));

    p_latch_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.latched && rb_q.rd_hi && data_rd && !mode_wr) |=> !rb_q.latched);
endmodule

// File: rtl/interval_timer_chan.sv
`timescale 1ns/1ps
module interval_timer_chan
    import itc_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_OFS = 0,
    parameter int CTRL_OFS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_out
);
    logic             mode_wr, latch_cmd, data_wr, data_rd;
    mode_e            mode_sel;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] rb_byte;

    itc_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS)
    ) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .latch_cmd(latch_cmd),
        .data_wr(data_wr), .data_rd(data_rd)
    );

    itc_count_core u_core (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .data_wr(data_wr), .wdata(wdata), .count_o(cnt), .out_o(irq_out)
    );

    itc_readback u_rb (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .latch_cmd(latch_cmd),
        .data_rd(data_rd), .live_cnt(cnt), .rd_byte(rb_byte)
    );

    assign rdata = data_rd ? rb_byte : '0;
endmodule

// File: tb/sim_interval_timer_chan.sv
`timescale 1ns/1ps
module sim_interval_timer_chan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_out;

    int checks = 0, failures = 0, cyc = 0, ld = 0;
    bit done = 1'b0;

    interval_timer_chan u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output int d);
        rd_en = 1'b1; addr = a;
        #1 d = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] cw, input int n);
        bus_wr(2'd3, cw);
        bus_wr(2'd0, 8'(n));
        bus_wr(2'd0, 8'(n >> 8));
        ld = cyc;
    endtask

    task automatic wait_k(input int k);
        while (cyc < ld + k) @(negedge clk);
    endtask

    task automatic read16(output int v);
        int lo, hi;
        bus_rd(2'd0, lo);
        bus_rd(2'd0, hi);
        v = lo | (hi << 8);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, w, cl, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 irq", irq_out, 1);
        read16(v);
        chk("R13 count", v, 0);
        bus_rd(2'd3, v);
        chk("R1 ctrl read", v, 0);

        // R5 terminal-count sweep
        for (int n = 1; n <= 20; n++) begin
            bus_wr(2'd3, 8'h30);
            chk("R5 low after ctrl", irq_out, 0);
            bus_wr(2'd0, 8'(n));
            bus_wr(2'd0, 8'h00);
            ld = cyc;
            wait_k(n - 1); chk("R5 before tc", irq_out, 0);
            wait_k(n);     chk("R5 at tc", irq_out, 1);
            wait_k(n + 3); chk("R5 sticky", irq_out, 1);
        end

        // R6 rate-generator sweep
        for (int n = 2; n <= 8; n++) begin
            load(8'h34, n);
            for (int k = 0; k < 3 * n; k++) begin
                wait_k(k);
                chk("R6 period", irq_out, ((k % n) == n - 1) ? 0 : 1);
            end
        end

        // R8 strobe sweep
        for (int n = 1; n <= 10; n++) begin
            load(8'h38, n);
            for (int k = 0; k <= n + 4; k++) begin
                wait_k(k);
                chk("R8 strobe", irq_out, (k == n) ? 0 : 1);
            end
        end

        // R7 new count mid-period: lo at k=9, hi at k=10, pulses 11, 17, 23
        load(8'h34, 4);
        wait_k(8);
        bus_wr(2'd0, 8'd6);
        bus_wr(2'd0, 8'd0);
        for (int k = 11; k <= 24; k++) begin
            wait_k(k);
            chk("R7 reload", irq_out, (k == 11 || k == 17 || k == 23) ? 0 : 1);
        end

        // R2 ignored control bytes while rate generator runs (N=5)
        load(8'h34, 5);
        bus_wr(2'd3, 8'h74);
        bus_wr(2'd3, 8'h3E);
        bus_wr(2'd3, 8'h10);
        bus_wr(2'd3, 8'hB4);
        for (int k = 4; k <= 15; k++) begin
            wait_k(k);
            chk("R2 ignored cw", irq_out, ((k % 5) == 4) ? 0 : 1);
        end

        // R10 latch while counting (N=0x7FFF, rate)
        load(8'h34, 16'h7FFF);
        wait_k(20);
        bus_wr(2'd3, 8'h00);
        cl = cyc;
        read16(v);
        chk("R10 snapshot", v, 16'h7FFF - (cl - 1 - ld));
        // R11 second latch ignored while pending
        bus_wr(2'd3, 8'h00);
        cl = cyc;
        repeat (10) @(negedge clk);
        bus_wr(2'd3, 8'h00);
        read16(v);
        chk("R11 first snapshot kept", v, 16'h7FFF - (cl - 1 - ld));
        bus_wr(2'd3, 8'h00);
        cl = cyc;
        read16(v);
        chk("R10 new snapshot", v, 16'h7FFF - (cl - 1 - ld));

        // R4 control byte freezes count; R12 live reads
        load(8'h30, 16'h1234);
        wait_k(7);
        bus_wr(2'd3, 8'h30);
        held = 16'h1234 - (cyc - 1 - ld);
        read16(v);
        chk("R12 live held", v, held);
        repeat (30) @(negedge clk);
        chk("R4 no irq", irq_out, 0);
        read16(v);
        chk("R4 frozen", v, held);
        read16(w);
        chk("R12 alternation", w, held);
        // R1 writes to other offsets ignored
        bus_wr(2'd1, 8'h55);
        bus_wr(2'd2, 8'hAA);
        read16(v);
        chk("R1 other offsets", v, held);
        bus_rd(2'd1, v);
        chk("R1 read offset1", v, 0);
        // R3 byte order and pointer: lo then hi from here starts a count of 3
        bus_wr(2'd0, 8'd3);
        chk("R3 not started after lo", irq_out, 0);
        read16(v);
        chk("R3 held after lo", v, held);
        bus_wr(2'd0, 8'd0);
        ld = cyc;
        wait_k(2); chk("R3 count", irq_out, 0);
        wait_k(3); chk("R3 count tc", irq_out, 1);

        // R4 pointer reset: half a count then control byte
        bus_wr(2'd3, 8'h38);
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd3, 8'h38);
        load(8'h38, 4);
        wait_k(4); chk("R4 ptr reset", irq_out, 0);
        wait_k(5); chk("R4 ptr reset after", irq_out, 1);

        // R9 zero count is 65536
        load(8'h30, 0);
        wait_k(65535); chk("R9 before", irq_out, 0);
        wait_k(65536); chk("R9 at", irq_out, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule